// File: doc/BRIEF.md
# Prescaled Reloadable Watchdog Counter

This block guards a small processor system against a stalled program. It runs off the system clock alone. A long fixed prescaler divides that clock, and each prescaler period advances an 8-bit counter by one. Software keeps the system alive by writing a refresh bit. The refresh loads the counter from a programmable reload register and restarts the prescaler. If no refresh comes in time, the counter reaches its terminal count. At that point a sticky timeout flag is set and, when reset generation is enabled, a fixed-length internal reset pulse is issued.

Software reaches the block through a one-bit register select, a write strobe, write data and a combinational read port. The control register holds enable, reset-enable, refresh and timeout-flag bits, and the second register holds the reload value. An idle input freezes all counting. The active-low reset input stands for both power-on and external reset and returns the whole block to its reset state.

The watchdog's own reset pulse is an output only. It resets no register inside the block, so the flag it leaves behind survives that pulse. After the pulse the block restarts a fresh period from the reload value.

Top module: `wdog_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the control register reads 0, the reload register reads 0 and `wdt_rst_o` is 0. This includes the timeout flag.
- R2: With `reg_sel`=0 the control register is addressed: bit 0 is enable, bit 1 is reset-enable, bit 2 is refresh (write 1 to act, always reads 0) and bit 3 is the timeout flag. With `reg_sel`=1 the reload register is addressed and reads back what was written.
- R3: With enable set, the first timeout occurs (255 − reload) × PRESCALE clock edges after the edge that samples a refresh write, for reload 0 to 254. With reload 255 it occurs PRESCALE edges after that edge.
- R4: A refresh loads the counter from the reload register and clears the prescaler, so refreshes spaced closer than one timeout period prevent every timeout.
- R5: A timeout sets the timeout flag (control bit 3).
- R6: Writing 1 to control bit 3 clears the flag, and writing 0 leaves it unchanged. A timeout in the same cycle wins over the clear.
- R7: The timeout flag keeps its value through the internal reset pulse.
- R8: On a timeout with reset-enable set, `wdt_rst_o` is high for exactly RST_PULSE clock cycles. With reset-enable clear, `wdt_rst_o` stays low and only the flag is set.
- R9: While `idle_i` is high, neither the prescaler nor the counter advances, so each idle cycle delays the timeout by one cycle.
- R10: With enable clear, no timeout occurs.
- R11: Counting is held during the reset pulse. Afterwards the counter restarts from the reload value, so the next timeout follows RST_PULSE + (255 − reload) × PRESCALE edges after the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, sole time base |
| rst_n | input | 1 | Active-low power-on/external reset, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 reload |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Combinational read data of the selected register |
| idle_i | input | 1 | Idle mode: freezes counting while high |
| wdt_rst_o | output | 1 | Internal reset pulse request |

## Verification
A prescaler or counter that is off by one moves the rising edge of `wdt_rst_o` by one edge or by one full prescaler period. The bench therefore predicts the exact edge of every rising edge from the refresh edge and the idle cycles, and catches such an error at the first timeout. A flag that clears wrongly or fails to set shows on the next control read. A missing reset-enable gate shows as an unexpected pulse within one timeout period. A pulse of the wrong length shows at its falling edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Control register bit positions (software-visible layout)
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_RSTEN = 1;
  localparam int unsigned CTL_KICK  = 2;
  localparam int unsigned CTL_FLAG  = 3;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_RELOAD = 1'b1} reg_sel_e;

  // Ticks from a refresh to the timeout edge, for a counter of cw bits
  function automatic int unsigned ticks_to_timeout(input int unsigned reload,
                                                   input int unsigned cw);
    int unsigned top;
    top = (32'd1 << cw) - 1;
    return (reload >= top) ? 1 : (top - reload);
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned PRESCALE = 344064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (clear)      div_q <= '0;
    else if (run)        div_q <= (div_q == LAST) ? '0 : div_q + PW'(1);
  end

  assign tick = run && (div_q == LAST);

  if (PRESCALE > 1) begin : g_chk
    // R4: a cleared prescaler cannot tick on the next edge
    assert_fresh_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !tick);
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          refresh,
  input  logic [CW-1:0] reload,
  output logic          timeout,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TERM = CW'((1 << CW) - 2);

  logic [CW-1:0] cnt_q;
  logic          at_term;

  assign at_term = (cnt_q >= TERM);
  assign timeout = tick && !refresh && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (refresh || timeout) cnt_q <= reload;
    else if (tick)               cnt_q <= cnt_q + CW'(1);
  end

  assign count = cnt_q;

  assert_reload_on_refresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> count == $past(reload));
  assert_restart_after_timeout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> count == $past(reload));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned RST_PULSE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned PCW = $clog2(RST_PULSE + 1);

  logic [PCW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left_q <= '0;
    else if (fire)          left_q <= PCW'(RST_PULSE);
    else if (left_q != '0)  left_q <= left_q - PCW'(1);
  end

  assign active = (left_q != '0);

  assert_pulse_needs_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(fire));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  input  logic          timeout,
  output logic [DW-1:0] rdata,
  output logic          en,
  output logic          rst_en,
  output logic          refresh,
  output logic          flag,
  output logic [DW-1:0] reload
);
  logic          en_q, rsten_q, flag_q;
  logic [DW-1:0] reload_q;
  logic          ctrl_wr, rel_wr, flag_clr;

  assign ctrl_wr  = wr && (sel == SEL_CTRL);
  assign rel_wr   = wr && (sel == SEL_RELOAD);
  assign refresh  = ctrl_wr && wdata[CTL_KICK];
  assign flag_clr = ctrl_wr && wdata[CTL_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q    <= wdata[CTL_EN];
        rsten_q <= wdata[CTL_RSTEN];
      end
      if (rel_wr) reload_q <= wdata;
    end
  end

  // Sticky flag: only the block reset clears it besides a write of 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (timeout)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_RELOAD) begin
      rdata = reload_q;
    end else begin
      rdata[CTL_EN]    = en_q;
      rdata[CTL_RSTEN] = rsten_q;
      rdata[CTL_FLAG]  = flag_q;
    end
  end

  assign en     = en_q;
  assign rst_en = rsten_q;
  assign flag   = flag_q;
  assign reload = reload_q;

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> flag);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);
  assert_flag_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !timeout |=> !flag);
endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int unsigned PRESCALE  = 344064,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RST_PULSE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             idle_i,
  output logic             wdt_rst_o
);
  logic             en, rst_en, refresh, flag;
  logic [CNT_W-1:0] reload, count;
  logic             run, tick, timeout, fire, pulse_on;

  // Named internal events
  assign run  = en && !idle_i && !pulse_on;
  assign fire = timeout && rst_en;

  wdog_regs #(.DW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .timeout(timeout), .rdata(reg_rdata), .en(en), .rst_en(rst_en),
    .refresh(refresh), .flag(flag), .reload(reload)
  );

  wdog_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(refresh || timeout), .tick(tick)
  );

  wdog_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .refresh(refresh),
    .reload(reload), .timeout(timeout), .count(count)
  );

  wdog_pulse #(.RST_PULSE(RST_PULSE)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .active(pulse_on)
  );

  assign wdt_rst_o = pulse_on;

  assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i && !refresh |=> $stable(count));
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !timeout);
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !rst_en && !wdt_rst_o |=> !wdt_rst_o);
  assert_flag_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> flag);
endmodule

// File: tb/tb_wdog_top.sv
module tb_wdog_top;
  localparam int unsigned P  = 8;
  localparam int unsigned RP = 4;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0, idle = 1'b0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          wdt_rst;

  always #5 clk = ~clk;

  wdog_top #(.PRESCALE(P), .CNT_W(CW), .RST_PULSE(RP)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(wdata), .reg_rdata(rdata), .idle_i(idle), .wdt_rst_o(wdt_rst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, fails = 0, rises = 0;
  bit done = 0;
  int exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Period in edges from a refresh edge, restated from R3
  function automatic int period(input int reload);
    return (reload == 255) ? P : (255 - reload) * P;
  endfunction

  // Monitor: pops the expected rise edge, checks pulse length
  logic prev = 0;
  int   len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst && !prev) begin
        rises++;
        len = 0;
        if (exp_q.size() == 0) chk(0, "R8 unexpected pulse", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, "R3/R11 pulse edge", cyc, e);
        end
      end
      if (wdt_rst) len++;
      if (!wdt_rst && prev) chk(len == RP, "R8 pulse length", len, RP);
      prev = wdt_rst;
    end
  end

  task automatic wr(input logic sel, input logic [CW-1:0] d, output int edge_idx);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; wdata = d;
    @(negedge clk);
    edge_idx = cyc;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [CW-1:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = rdata;
  endtask

  task automatic quiet();
    while (exp_q.size() != 0 || wdt_rst) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] v;
    int k, base;
    repeat (3) @(negedge clk);
    rd(0, v); chk(v == 0, "R1 ctrl in reset", v, 0);
    chk(wdt_rst == 0, "R1 pulse in reset", wdt_rst, 0);
    rst_n = 1'b1;
    rd(1, v); chk(v == 0, "R1 reload after reset", v, 0);

    // Test A: reload 250, reset-enable on, two pulses back to back
    wr(1, 8'd250, k); rd(1, v); chk(v == 250, "R2 reload readback", v, 250);
    wr(0, 8'h07, k);
    exp_q.push_back(k + period(250));
    exp_q.push_back(k + period(250) + RP + period(250));
    rd(0, v); chk(v == 8'h03, "R2 refresh bit reads 0", v, 3);
    quiet();
    rd(0, v); chk(v == 8'h0B, "R5 R7 flag after pulses", v, 11);
    wr(0, 8'h00, k);
    rd(0, v); chk(v == 8'h08, "R6 write 0 keeps flag", v, 8);
    base = rises;
    repeat (300) @(negedge clk);
    chk(rises == base, "R10 disabled no pulse", rises, base);
    rd(0, v); chk(v == 8'h08, "R10 flag unchanged when disabled", v, 8);
    wr(0, 8'h08, k);
    rd(0, v); chk(v == 8'h00, "R6 write 1 clears flag", v, 0);

    // Test C: reset-enable off, flag only
    wr(1, 8'd253, k); wr(0, 8'h05, k);
    base = rises;
    repeat (40) @(negedge clk);
    chk(rises == base, "R8 no pulse without reset-enable", rises, base);
    rd(0, v); chk(v == 8'h09, "R5 flag set without pulse", v, 9);
    wr(0, 8'h08, k);

    // Test B: refresh keeps it alive at reload 254
    wr(1, 8'd254, k);
    base = rises;
    for (int i = 0; i < 10; i++) begin
      wr(0, 8'h07, k);
      repeat (5) @(negedge clk);
    end
    chk(rises == base, "R4 refresh prevents timeout", rises, base);
    exp_q.push_back(k + period(254));
    quiet();
    wr(0, 8'h08, k);

    // Test D: idle freezes counting for 10 edges
    wr(1, 8'd252, k); wr(0, 8'h07, k);
    exp_q.push_back(k + period(252) + 10);
    repeat (5) @(negedge clk);
    idle = 1'b1;
    repeat (10) @(negedge clk);
    idle = 1'b0;
    quiet();
    wr(0, 8'h08, k);

    // Test E: reload 255 gives one prescaler period
    wr(1, 8'd255, k); wr(0, 8'h07, k);
    exp_q.push_back(k + period(255));
    quiet();
    wr(0, 8'h08, k);
    rd(0, v); chk(v == 8'h00, "R6 cleared after reload 255 test", v, 0);

    // External reset in the middle of operation
    wr(1, 8'd200, k); wr(0, 8'h03, k);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(0, v); chk(v == 0, "R1 ctrl after external reset", v, 0);
    rd(1, v); chk(v == 0, "R1 reload after external reset", v, 0);
    chk(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule